// File: doc/BRIEF.md
# Variable-Width Programmable AND-OR Array

This block is the logic core of a small programmable logic device. Array inputs come in on one bus and each is presented to the AND plane twice: once as it is and once inverted. A set of product terms, each formed from whichever columns its connection row selects, then feeds a row of OR sums whose term counts differ from output to output. The smallest groups sit at the two ends and the largest in the middle. Beyond the sums, the array gives every output one product term of its own for that output's enable. It also has two product terms shared by all outputs: an asynchronous-reset term and a synchronous-preset term. These spare the ordinary sums from spending terms on initialisation.

The connection pattern sits in a clocked store. After reset it holds the pattern given by a parameter, and it can be rewritten at run time through a one-bit shift port. From the array inputs to every term output the path is purely combinational. The device-level wrapper feeds the array with dedicated input pins and with the feedback from its output cells, and it consumes the sums, enables and control terms in its macrocells.

Top module: `pla_array`

## Requirements
- R1: Column 2i carries array input i and column 2i+1 carries its inverse. A connection bit of 1 ties a column into a term, and each product term is the AND of all the columns tied to it.
- R2: A product term with no connected columns evaluates to 1.
- R3: A term that ties in both the true and the inverted column of one input is always 0. In the erased state, where every bit is 1, all outputs read 0.
- R4: Sum k owns SUM_BASE + SUM_STEP*min(k, N_OUT-1-k) product terms. The groups take consecutive term indices, starting with sum 0 at term 0, so with the defaults the sizes are 8,10,12,14,16,16,14,12,10,8.
- R5: Each sum output is the OR of its own group of terms only. A true term in one group does not reach a neighbouring sum.
- R6: The term at index N_SUM+k, where N_SUM is the total number of sum terms, drives only enable output k.
- R7: Term N_SUM+N_OUT drives the asynchronous-reset output, and the term after it drives the synchronous-preset output.
- R8: While cfg_load_i is high, one bit per clock edge shifts in from cfg_bit_i. After a full load of N_PT*2*N_IN bits, the first bit sent sits at flat index 0, where flat index = term*2*N_IN + column.
- R9: While cfg_load_i is high, every sum, enable and control output is 0.
- R10: rst_ni low loads the INIT_CFG parameter, which is all ones (erased) by default. With cfg_load_i low, clock edges leave the pattern unchanged whatever cfg_bit_i does.
- R11: The outputs follow changes on in_i within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the connection store |
| rst_ni | input | 1 | Active-low asynchronous reset, loads INIT_CFG |
| cfg_load_i | input | 1 | Shift enable for the connection store |
| cfg_bit_i | input | 1 | Serial connection bit |
| in_i | input | N_IN | Array inputs |
| sum_o | output | N_OUT | OR sums |
| oe_o | output | N_OUT | Per-output enable terms |
| areset_o | output | 1 | Shared asynchronous-reset term |
| spreset_o | output | 1 | Shared synchronous-preset term |

## Verification
The bench builds the array with four inputs, four outputs, a base group size of 2 and a step of 1. This gives group sizes 2,3,3,2, sixteen terms and a 128-bit pattern. A full serial load then takes only 128 cycles, so the bench can reload the array several times and sweep all sixteen input values against a model written from the requirements. With this shape each group edge lies only a few terms apart, so the bench places single empty terms at the first and last index of a group and at the enable and control indices. Any shift in the offsets then shows up as a wrong output bit.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // terms owned by sum k: grows toward the middle, mirrored
  function automatic int sum_size(int k, int n_out, int base, int step);
    int d;
    d = (k < n_out - 1 - k) ? k : n_out - 1 - k;
    return base + step * d;
  endfunction

  function automatic int sum_off(int k, int n_out, int base, int step);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += sum_size(j, n_out, base, step);
    return acc;
  endfunction

  function automatic int sum_total(int n_out, int base, int step);
    return sum_off(n_out, n_out, base, step);
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_COL = 44,
  parameter int N_PT  = 132,
  parameter logic [N_PT*N_COL-1:0] INIT_CFG = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             bit_i,
  output logic [N_COL-1:0] rows_o [N_PT]
);
  localparam int NBITS = N_PT * N_COL;

  logic [NBITS-1:0] cfg_q;

  // first bit shifted in travels down to index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= INIT_CFG;
    else if (load_i) cfg_q <= {bit_i, cfg_q[NBITS-1:1]};
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_row
    assign rows_o[t] = cfg_q[t*N_COL +: N_COL];
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN = 22,
  parameter int N_PT = 132,
  localparam int N_COL = 2 * N_IN
) (
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_COL-1:0] rows_i [N_PT],
  input  logic             en_i,
  output logic [N_PT-1:0]  pt_o
);
  logic [N_COL-1:0] col;

  for (genvar i = 0; i < N_IN; i++) begin : g_col
    assign col[2*i]   = in_i[i];
    assign col[2*i+1] = ~in_i[i];
  end

  // unconnected columns read as 1, so an empty term is true
  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    assign pt_o[t] = en_i & (&(col | ~rows_i[t]));
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int N_OUT    = 10,
  parameter int SUM_BASE = 8,
  parameter int SUM_STEP = 2,
  localparam int N_SUM = sum_total(N_OUT, SUM_BASE, SUM_STEP),
  localparam int N_PT  = N_SUM + N_OUT + 2
) (
  input  logic [N_PT-1:0]  pt_i,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_o,
  output logic             ar_o,
  output logic             sp_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_sum
    localparam int OFF = sum_off(k, N_OUT, SUM_BASE, SUM_STEP);
    localparam int SZ  = sum_size(k, N_OUT, SUM_BASE, SUM_STEP);
    assign sum_o[k] = |pt_i[OFF +: SZ];
    assign oe_o[k]  = pt_i[N_SUM + k];
  end

  assign ar_o = pt_i[N_SUM + N_OUT];
  assign sp_o = pt_i[N_SUM + N_OUT + 1];
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN     = 22,
  parameter int N_OUT    = 10,
  parameter int SUM_BASE = 8,
  parameter int SUM_STEP = 2,
  localparam int N_COL = 2 * N_IN,
  localparam int N_SUM = sum_total(N_OUT, SUM_BASE, SUM_STEP),
  localparam int N_PT  = N_SUM + N_OUT + 2,
  parameter logic [N_PT*N_COL-1:0] INIT_CFG = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic             cfg_bit_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_o,
  output logic             areset_o,
  output logic             spreset_o
);
  logic [N_COL-1:0] cfg_rows [N_PT];
  logic [N_PT-1:0]  pt;

  pla_cfg_store #(
    .N_COL    (N_COL),
    .N_PT     (N_PT),
    .INIT_CFG (INIT_CFG)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .bit_i  (cfg_bit_i),
    .rows_o (cfg_rows)
  );

  // terms forced low while the pattern is in motion
  pla_and_plane #(
    .N_IN (N_IN),
    .N_PT (N_PT)
  ) u_and (
    .in_i   (in_i),
    .rows_i (cfg_rows),
    .en_i   (~cfg_load_i),
    .pt_o   (pt)
  );

  pla_or_plane #(
    .N_OUT    (N_OUT),
    .SUM_BASE (SUM_BASE),
    .SUM_STEP (SUM_STEP)
  ) u_or (
    .pt_i  (pt),
    .sum_o (sum_o),
    .oe_o  (oe_o),
    .ar_o  (areset_o),
    .sp_o  (spreset_o)
  );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN  = 22,
  parameter int N_OUT = 10,
  parameter int N_COL = 44
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_load_i,
  input logic [N_IN-1:0]  in_i,
  input logic [N_OUT-1:0] sum_i,
  input logic [N_OUT-1:0] oe_i,
  input logic             ar_i,
  input logic             sp_i,
  input logic [N_COL-1:0] ar_row_i,
  input logic [N_COL-1:0] sp_row_i
);
  logic [2*N_OUT+1:0] outs;
  assign outs = {sp_i, ar_i, oe_i, sum_i};

  AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |-> (outs == '0)); // R9

  AST_EMPTY_TRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && ar_row_i == '0) |-> ar_i); // R2

  AST_ERASED_FALSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&ar_row_i) || (&sp_row_i)) |-> ((ar_i == 1'b0 || !(&ar_row_i)) && (sp_i == 1'b0 || !(&sp_row_i)))); // R3

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && !$past(cfg_load_i) && $stable(in_i)) |-> $stable(outs)); // R10
endmodule

bind pla_array pla_array_chk #(
  .N_IN  (N_IN),
  .N_OUT (N_OUT),
  .N_COL (N_COL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .in_i       (in_i),
  .sum_i      (sum_o),
  .oe_i       (oe_o),
  .ar_i       (areset_o),
  .sp_i       (spreset_o),
  .ar_row_i   (cfg_rows[N_PT-2]),
  .sp_row_i   (cfg_rows[N_PT-1])
);

// File: tb/tb_pla_array.sv
module tb_pla_array;
  localparam int NI = 4, NO = 4, NC = 8, NP = 16, NB = NP * NC;

  logic clk = 0, rst_n = 0, load = 0, cbit = 0;
  logic [NI-1:0] x = '0;
  logic [NO-1:0] sum, oe;
  logic ar, sp;
  logic [7:0] m [NP];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pla_array #(.N_IN(NI), .N_OUT(NO), .SUM_BASE(2), .SUM_STEP(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(load), .cfg_bit_i(cbit),
    .in_i(x), .sum_o(sum), .oe_o(oe), .areset_o(ar), .spreset_o(sp));

  function automatic logic [9:0] got();
    return {sp, ar, oe, sum};
  endfunction

  // reference from requirements: groups 2,3,3,2 at 0,2,5,8; enables 10..13; ar 14; sp 15
  function automatic logic [9:0] model(logic [3:0] v);
    logic [7:0] c;
    logic [15:0] p;
    for (int i = 0; i < 4; i++) begin c[2*i] = v[i]; c[2*i+1] = ~v[i]; end
    for (int t = 0; t < 16; t++) p[t] = &(c | ~m[t]);
    return {p[15], p[14], p[13:10], |p[9:8], |p[7:5], |p[4:2], |p[1:0]};
  endfunction

  task automatic check(string req, logic [9:0] g, logic [9:0] e);
    n_run++;
    if (g !== e) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, g, e);
    end
  endtask

  task automatic fill(logic [7:0] v);
    for (int t = 0; t < NP; t++) m[t] = v;
  endtask

  task automatic load_cfg();
    @(negedge clk);
    load = 1;
    for (int i = 0; i < NB; i++) begin
      cbit = m[i / NC][i % NC];
      if (i == NB / 2) begin
        x = 4'hF; #2;
        check("R9 quiet during load", got(), 10'h000);
      end
      @(negedge clk);
    end
    load = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; load = 0; x = 4'h0;
    repeat (3) @(negedge clk);
    check("R10 reset erased", got(), 10'h000);
    rst_n = 1;
    @(negedge clk); x = 4'hA; #2;
    check("R3 erased after reset", got(), 10'h000);
  endtask

  task automatic t_blank();
    fill(8'h00);
    load_cfg();
    x = 4'h0; #2; check("R2 R8 blank in=0", got(), 10'h3FF);
    x = 4'hF; #2; check("R2 R8 blank in=F", got(), 10'h3FF);
  endtask

  task automatic t_program();
    fill(8'hFF);
    m[0]  = 8'b0000_1001; // in0 & ~in1
    m[4]  = 8'b0001_0000; // in2
    m[7]  = 8'b0100_0001; // in3 & in0
    m[9]  = 8'b1000_0000; // ~in3
    m[10] = 8'h00;        // always on
    m[13] = 8'b0000_0100; // in1
    m[14] = 8'b0101_0101; // all inputs high
    m[15] = 8'b0000_0010; // ~in0
    load_cfg();
    x = 4'b0001; #2;
    check("R1 hand vector", got(), 10'h019);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); x = v[3:0]; #2;
      check("R1 R4 R5 R6 R7 sweep", got(), model(v[3:0]));
    end
    // R11: change between edges, no clock in between
    @(negedge clk); x = 4'hF; #1; x = 4'h7; #2;
    check("R11 same-cycle response", got(), model(4'h7));
  endtask

  task automatic t_boundary();
    fill(8'hFF); m[2] = 8'h00; m[9] = 8'h00;
    load_cfg(); x = 4'h3; #2;
    check("R4 R5 first of sum1, last of sum3", got(), 10'h00A);
    fill(8'hFF); m[1] = 8'h00; m[10] = 8'h00;
    load_cfg(); x = 4'h5; #2;
    check("R4 R6 last of sum0, enable0", got(), 10'h011);
    fill(8'hFF); m[0] = 8'h03; m[7] = 8'h00; m[14] = 8'h00;
    load_cfg();
    x = 4'h0; #2; check("R3 R7 complement pair x0", got(), 10'h104);
    x = 4'h1; #2; check("R3 R7 complement pair x1", got(), 10'h104);
  endtask

  task automatic t_hold();
    logic [9:0] ref_v;
    x = 4'h1; #2; ref_v = got();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); cbit = i[0];
    end
    #2; check("R10 hold without load", got(), ref_v);
    rst_n = 0; #2;
    check("R10 reset reloads init", got(), 10'h000);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    t_reset();
    t_blank();
    t_program();
    t_boundary();
    t_hold();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule